// File: doc/BRIEF.md
# Selectable-Topology Prefix Adder

This block adds two unsigned binary words of parameterisable width and a carry-in, producing a sum word and a carry-out. Every bit position first forms a local generate (both operand bits set) and a local propagate (operand bits differ). A logarithmic-depth network of associative combine cells merges these local pairs into a group generate and a group propagate for each prefix of bits, from bit 0 up to that bit. The carry into each bit, and the final carry-out, then follows from the group pair and the external carry-in. Each sum bit is the local propagate XORed with its incoming carry.

The shape of the combine network is chosen at elaboration time from three variants. The dense variant combines every position at doubling distances. It has the minimum depth and the most cells. The sparse variant first runs an up-sweep that builds power-of-two spans. A mirrored down-sweep then fills the positions still missing. It has nearly twice the depth and the fewest cells. The hybrid variant runs the dense scheme on odd positions only, then adds one level that completes the even positions from their odd neighbours. All three give identical results. The sum and carry-out are captured in an output register with a synchronous reset, so a result appears one clock after its operands are sampled.

Top module: `prefix_adder`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, `sum_o` and `cout_o` are cleared to zero at that edge, whatever the operand inputs hold.
- R2: With `rst` low, after each rising edge the 17-bit value {`cout_o`,`sum_o`} (default width 16) equals `a_i + b_i + cin_i` as sampled at that edge, treated as unsigned.
- R3: When every bit of `a_i` differs from the matching bit of `b_i`, the next `cout_o` equals the sampled `cin_i`. The next `sum_o` is all ones when `cin_i` is 0, and all zeros when `cin_i` is 1.
- R4: When the most significant bits of `a_i` and `b_i` are both 1, the next `cout_o` is 1. When both are 0, the next `cout_o` is 0.
- R5: Zero plus zero with `cin_i` = 1 gives `sum_o` = 1 and `cout_o` = 0.
- R6: All ones plus one with `cin_i` = 0 gives `sum_o` = 0 and `cout_o` = 1. This is the longest possible carry chain.
- R7: The dense, sparse and hybrid network variants, selected by parameter `TOPO`, produce bit-identical outputs for identical inputs.
- R8: Bit 0 of the next `sum_o` equals `a_i[0]` XOR `b_i[0]` XOR `cin_i`, independent of the network variant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the operands are sampled and the result is registered on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the result register |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Registered sum |
| cout_o | output | 1 | Registered carry out of the top bit |

## Verification
The assertions assume that the operands and carry-in hold defined, non-X values at every rising edge outside reset. They also assume that reset is high at the first edge, so that every history they look back on begins inside reset. The stimulus is driven only on falling edges, always with fully specified values. Reset is held from time zero, so each sampled operand set is settled half a period before the edge that captures it.

// File: rtl/adder_pkg.sv
package adder_pkg;

  typedef enum logic [1:0] {
    TOPO_DENSE  = 2'd0,
    TOPO_SPARSE = 2'd1,
    TOPO_HYBRID = 2'd2
  } topo_e;

  // Number of combine levels for a given variant and log2 of the width.
  function automatic int tree_levels(topo_e t, int lg);
    case (t)
      TOPO_SPARSE: return (2 * lg) - 1;
      TOPO_HYBRID: return lg + 1;
      default:     return lg;
    endcase
  endfunction

  // Distance between the two inputs of a cell on a given level.
  function automatic int level_span(topo_e t, int lg, int lvl);
    case (t)
      TOPO_SPARSE: return (lvl < lg) ? (1 << lvl) : (1 << ((2 * lg) - 2 - lvl));
      TOPO_HYBRID: return (lvl < lg) ? (1 << lvl) : 1;
      default:     return 1 << lvl;
    endcase
  endfunction

  // Whether bit position i holds a combine cell on a given level.
  function automatic bit cell_here(topo_e t, int lg, int lvl, int i);
    int d;
    d = level_span(t, lg, lvl);
    case (t)
      TOPO_SPARSE: begin
        if (lvl < lg) return ((i + 1) % (2 * d)) == 0;
        else          return (((i + 1) % (2 * d)) == d) && (i >= 2 * d);
      end
      TOPO_HYBRID: begin
        if (lvl < lg) return ((i % 2) == 1) && (i >= d);
        else          return ((i % 2) == 0) && (i >= 2);
      end
      default: return i >= d;
    endcase
  endfunction

endpackage

// File: rtl/pg_stage.sv
module pg_stage #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] gen_o,
  output logic [WIDTH-1:0] prop_o
);
  assign gen_o  = a_i & b_i;
  assign prop_o = a_i ^ b_i;
endmodule

// File: rtl/prefix_cell.sv
module prefix_cell (
  input  logic g_hi,
  input  logic p_hi,
  input  logic g_lo,
  input  logic p_lo,
  output logic g_o,
  output logic p_o
);
  assign g_o = g_hi | (p_hi & g_lo);
  assign p_o = p_hi & p_lo;
endmodule

// File: rtl/prefix_network.sv
module prefix_network
  import adder_pkg::*;
#(
  parameter int    WIDTH = 16,
  parameter topo_e TOPO  = TOPO_DENSE
) (
  input  logic [WIDTH-1:0] gen_i,
  input  logic [WIDTH-1:0] prop_i,
  output logic [WIDTH-1:0] grp_gen_o,
  output logic [WIDTH-1:0] grp_prop_o
);
  localparam int LG = $clog2(WIDTH);
  localparam int LV = tree_levels(TOPO, LG);

  logic [LV:0][WIDTH-1:0] gs;
  logic [LV:0][WIDTH-1:0] ps;

  assign gs[0] = gen_i;
  assign ps[0] = prop_i;

  for (genvar lv = 0; lv < LV; lv++) begin : g_level
    localparam int D = level_span(TOPO, LG, lv);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (cell_here(TOPO, LG, lv, i)) begin : g_cell
        prefix_cell u_cell (
          .g_hi (gs[lv][i]),
          .p_hi (ps[lv][i]),
          .g_lo (gs[lv][i-D]),
          .p_lo (ps[lv][i-D]),
          .g_o  (gs[lv+1][i]),
          .p_o  (ps[lv+1][i])
        );
      end else begin : g_pass
        assign gs[lv+1][i] = gs[lv][i];
        assign ps[lv+1][i] = ps[lv][i];
      end
    end
  end

  assign grp_gen_o  = gs[LV];
  assign grp_prop_o = ps[LV];
endmodule

// File: rtl/sum_stage.sv
module sum_stage #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] prop_i,
  input  logic [WIDTH-1:0] grp_gen_i,
  input  logic [WIDTH-1:0] grp_prop_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  logic [WIDTH:0] carry;

  // Carry into bit i+1 from the prefix pair of bits i..0 and the external carry.
  assign carry[0]       = cin_i;
  assign carry[WIDTH:1] = grp_gen_i | (grp_prop_i & {WIDTH{cin_i}});

  assign sum_o  = prop_i ^ carry[WIDTH-1:0];
  assign cout_o = carry[WIDTH];
endmodule

// File: rtl/prefix_adder.sv
module prefix_adder
  import adder_pkg::*;
#(
  parameter int    WIDTH = 16,
  parameter topo_e TOPO  = TOPO_DENSE
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  logic [WIDTH-1:0] gen_bit, prop_bit;
  logic [WIDTH-1:0] grp_gen, grp_prop;
  logic [WIDTH-1:0] sum_comb;
  logic             cout_comb;

  pg_stage #(.WIDTH(WIDTH)) u_pg (
    .a_i    (a_i),
    .b_i    (b_i),
    .gen_o  (gen_bit),
    .prop_o (prop_bit)
  );

  prefix_network #(.WIDTH(WIDTH), .TOPO(TOPO)) u_net (
    .gen_i      (gen_bit),
    .prop_i     (prop_bit),
    .grp_gen_o  (grp_gen),
    .grp_prop_o (grp_prop)
  );

  sum_stage #(.WIDTH(WIDTH)) u_sum (
    .prop_i     (prop_bit),
    .grp_gen_i  (grp_gen),
    .grp_prop_i (grp_prop),
    .cin_i      (cin_i),
    .sum_o      (sum_comb),
    .cout_o     (cout_comb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_o  <= '0;
      cout_o <= 1'b0;
    end else begin
      sum_o  <= sum_comb;
      cout_o <= cout_comb;
    end
  end
endmodule

// File: rtl/prefix_adder_checker.sv
module prefix_adder_checker #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             cin_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             cout_o
);
  a_r2_arith_result: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ({cout_o, sum_o} == ({1'b0, $past(a_i)} + {1'b0, $past(b_i)}
                                  + {{WIDTH{1'b0}}, $past(cin_i)})));

  a_r3_full_propagate: assert property (@(posedge clk) disable iff (rst)
    (&(a_i ^ b_i)) |=> (cout_o == $past(cin_i)) && (sum_o == {WIDTH{~$past(cin_i)}}));

  a_r4_msb_generate: assert property (@(posedge clk) disable iff (rst)
    (a_i[WIDTH-1] && b_i[WIDTH-1]) |=> cout_o);

  a_r4_msb_kill: assert property (@(posedge clk) disable iff (rst)
    (!a_i[WIDTH-1] && !b_i[WIDTH-1]) |=> !cout_o);

  a_r8_low_bit: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (sum_o[0] == ($past(a_i[0]) ^ $past(b_i[0]) ^ $past(cin_i))));
endmodule

bind prefix_adder prefix_adder_checker #(.WIDTH(WIDTH)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .a_i    (a_i),
  .b_i    (b_i),
  .cin_i  (cin_i),
  .sum_o  (sum_o),
  .cout_o (cout_o)
);

// File: tb/prefix_adder_bench.sv
module prefix_adder_bench;
  import adder_pkg::*;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a   = '1;
  logic [W-1:0] b   = '1;
  logic         cin = 1'b1;

  always #2 clk = ~clk;

  logic [W-1:0] s_dn, s_sp, s_hy;
  logic         c_dn, c_sp, c_hy;

  prefix_adder #(.WIDTH(W), .TOPO(TOPO_DENSE)) u_prefix_adder (
    .clk(clk), .rst(rst), .a_i(a), .b_i(b), .cin_i(cin), .sum_o(s_dn), .cout_o(c_dn));
  prefix_adder #(.WIDTH(W), .TOPO(TOPO_SPARSE)) u_prefix_adder_sp (
    .clk(clk), .rst(rst), .a_i(a), .b_i(b), .cin_i(cin), .sum_o(s_sp), .cout_o(c_sp));
  prefix_adder #(.WIDTH(W), .TOPO(TOPO_HYBRID)) u_prefix_adder_hy (
    .clk(clk), .rst(rst), .a_i(a), .b_i(b), .cin_i(cin), .sum_o(s_hy), .cout_o(c_hy));

  typedef struct packed {
    logic [W:0]   res;
    logic [W-1:0] opa;
    logic [W-1:0] opb;
    logic         ci;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{17'h00000, 16'h0000, 16'h0000, 1'b0},
    '{17'h00001, 16'h0000, 16'h0000, 1'b1},  // R5
    '{17'h10000, 16'hFFFF, 16'h0001, 1'b0},  // R6
    '{17'h10000, 16'hFFFF, 16'h0000, 1'b1},  // R3
    '{17'h0FFFF, 16'hFFFF, 16'h0000, 1'b0},  // R3
    '{17'h10000, 16'hAAAA, 16'h5555, 1'b1},  // R3
    '{17'h10000, 16'h8000, 16'h8000, 1'b0},  // R4
    '{17'h08000, 16'h7FFF, 16'h0001, 1'b0},  // R4
    '{17'h05555, 16'h1234, 16'h4321, 1'b0},
    '{17'h1FFFF, 16'hFFFF, 16'hFFFF, 1'b1},
    '{17'h0100F, 16'h00FF, 16'h0F0F, 1'b1},
    '{17'h11DE1, 16'hC3A5, 16'h5A3C, 1'b0}
  };

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  task automatic check(string req, logic [W:0] act, logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(string req, logic [W:0] exp);
    check({req, " dense"},  {c_dn, s_dn}, exp);
    check({req, " sparse"}, {c_sp, s_sp}, exp);
    check({req, " hybrid"}, {c_hy, s_hy}, exp);
    check({req, " R7 variants agree"}, {c_sp, s_sp} ^ {c_hy, s_hy}, {c_dn, s_dn} ^ {c_dn, s_dn});
  endtask

  // Drive on a falling edge, let one rising edge capture, sample on the next falling edge.
  task automatic apply(logic [W-1:0] va, logic [W-1:0] vb, logic vc);
    @(negedge clk);
    a = va; b = vb; cin = vc;
    @(negedge clk);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check_all("R1 reset clears outputs", '0);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      apply(VECS[k].opa, VECS[k].opb, VECS[k].ci);
      check_all($sformatf("R2 table vector %0d", k), VECS[k].res);
    end

    apply(16'h0000, 16'h0000, 1'b1);
    check_all("R5 carry-in alone", 17'h00001);
    apply(16'hFFFF, 16'h0001, 1'b0);
    check_all("R6 all ones plus one", 17'h10000);
    apply(16'h5555, 16'hAAAA, 1'b0);
    check_all("R3 full propagate no carry", 17'h0FFFF);
    apply(16'h0F0F, 16'hF0F0, 1'b1);
    check_all("R3 full propagate with carry", 17'h10000);
    apply(16'h8001, 16'h8000, 1'b0);
    check_all("R4 msb generate", 17'h10001);
    apply(16'h7FFF, 16'h7FFF, 1'b1);
    check_all("R4 msb kill", 17'h0FFFF);

    for (int k = 0; k < 300; k++) begin
      logic [W-1:0] ra, rb;
      logic         rc;
      ra = W'($urandom);
      rb = W'($urandom);
      rc = 1'($urandom);
      apply(ra, rb, rc);
      check_all("R2 random", {1'b0, ra} + {1'b0, rb} + {{W{1'b0}}, rc});
      check("R8 low sum bit", {{W{1'b0}}, s_dn[0]}, {{W{1'b0}}, ra[0] ^ rb[0] ^ rc});
    end

    // Reset in the middle of a run, with operands that would give a nonzero result.
    @(negedge clk);
    a = 16'hFFFF; b = 16'h0001; cin = 1'b1; rst = 1'b1;
    @(negedge clk);
    check_all("R1 mid-run reset", '0);
    rst = 1'b0;
    @(negedge clk);
    check_all("R2 after reset release", 17'h10001);

    done = 1'b1;
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      report();
    end
  end
endmodule